// File: doc/BRIEF.md
# ADC Scan List Sequencer

This block walks a scan list of eight 3-bit channel selectors and hands out conversion requests to one converter (sequential mode) or to two converters working side by side (parallel mode). A start pulse takes a snapshot of the list, the disable mask and the mode bits. The block then issues one slot, or one pair of slots, at a time. It moves to the next step only after every converter in use has returned its done handshake. When the last step is acknowledged it raises a one-cycle completion pulse.

The disable mask shortens the scan. The lowest disabled slot marks the end of the list, and a disabled slot is never skipped over. In parallel mode, converter A takes slots 0-3 and converter B takes slots 4-7 as matched pairs (j with j+4). Either half of a pair being disabled ends the scan for both converters at that pair. Each request carries the slot number as a tag, so that results can be put back in the right place. Each request also carries a channel number and a single-ended/differential flag.

Top module: `scan_sequencer`

## Requirements
- R1: While reset is held and after it is released, `req_a`, `req_b` and `scan_done` are low.
- R2: In sequential mode (`par_mode`=0), the active slots go out on converter A only, in increasing slot order. There is one `req_a` strobe per slot, and `tag_a` equals the slot number.
- R3: In sequential mode, if the lowest set bit of `dis_mask` is k, exactly slots 0..k-1 are issued. If no bit is set, all eight slots are issued.
- R4: In parallel mode (`par_mode`=1), step j asserts `req_a` and `req_b` in the same cycle with `tag_a`=j and `tag_b`=j+4, for j rising from 0.
- R5: In parallel mode, if j is the lowest index with `dis_mask[j]` or `dis_mask[j+4]` set, exactly pairs 0..j-1 are issued.
- R6: The next request is issued on the clock edge where every active converter has given its done, whichever of them came last. A done may arrive in the same cycle as its request, and the two converters' dones may arrive in any order or in the same cycle. Dones outside a scan are ignored.
- R7: If the first step is disabled (`dis_mask[0]`, or in parallel mode `dis_mask[0]` or `dis_mask[4]`), no request is issued and `scan_done` is high in the cycle right after the start cycle.
- R8: `scan_done` is high for the one cycle after the cycle in which the last outstanding done was given, and it is never high together with a request.
- R9: A `start` seen while a scan is in progress has no effect. This includes a `start` in the cycle that carries the final done.
- R10: With `diff_mode`=0, the channel output equals the slot's selector and the diff flag is 0. With `diff_mode`=1, the channel output is the selector with bit 0 cleared (the even input of the pair) and the diff flag is 1.
- R11: Slot k<4 is read from `list_lo` bits [4k+2:4k], and slot k>=4 from `list_hi` bits [4(k-4)+2:4(k-4)]. Bits 3, 7, 11 and 15 of each list word are ignored.
- R12: The lists, mask and mode bits are sampled in the start cycle. Changes to them during a scan do not alter the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| list_lo | input | 16 | Packed selectors for slots 0-3 |
| list_hi | input | 16 | Packed selectors for slots 4-7 |
| dis_mask | input | 8 | Per-slot disable mask, bit k for slot k |
| par_mode | input | 1 | 1 = paired two-converter scan, 0 = single converter |
| diff_mode | input | 1 | 1 = differential channel pairs |
| start | input | 1 | Start pulse |
| done_a | input | 1 | Converter A conversion done |
| done_b | input | 1 | Converter B conversion done |
| req_a | output | 1 | Converter A request strobe |
| chan_a | output | 3 | Converter A channel |
| diff_a | output | 1 | Converter A differential flag |
| tag_a | output | 3 | Converter A slot tag |
| req_b | output | 1 | Converter B request strobe |
| chan_b | output | 3 | Converter B channel |
| diff_b | output | 1 | Converter B differential flag |
| tag_b | output | 3 | Converter B slot tag |
| scan_done | output | 1 | Scan complete pulse |

## Verification
Two collisions matter most. The first is converter A's done landing in the same cycle as converter B's done. The second is a new `start` landing in the cycle that carries the final done. The bench provokes the first case with equal and with staggered response latencies, in both orders. It provokes the second by holding `start` high through a whole scan. A behavioural model built on a queue of pending slots is compared with the ports on every cycle. The bench also counts the requests issued per scan against a hand-computed figure, so an advance taken too early or a restart that should have been refused shows up as a mismatch.

// File: rtl/scan_pkg.sv
package scan_pkg;
   typedef enum logic {ST_IDLE, ST_BUSY} scan_st_e;
endpackage

// File: rtl/scan_limit.sv
module scan_limit #(
   parameter int NSLOT = 8,
   parameter int CNT_W = $clog2(NSLOT + 1)
) (
   input  logic [NSLOT-1:0] dis_mask,
   input  logic             par_mode,
   output logic [CNT_W-1:0] count
);
   localparam int HALF = NSLOT / 2;

   logic [CNT_W-1:0] seq_n;
   logic [CNT_W-1:0] par_n;

   // lowest disabled slot ends the single-converter list
   always_comb begin
      seq_n = CNT_W'(NSLOT);
      for (int k = NSLOT - 1; k >= 0; k--) begin
         if (dis_mask[k]) seq_n = CNT_W'(k);
      end
   end

   // lowest pair with either half disabled ends the paired list
   always_comb begin
      par_n = CNT_W'(HALF);
      for (int j = HALF - 1; j >= 0; j--) begin
         if (dis_mask[j] | dis_mask[j + HALF]) par_n = CNT_W'(j);
      end
   end

   assign count = par_mode ? par_n : seq_n;
endmodule

// File: rtl/chan_encode.sv
module chan_encode #(
   parameter int SEL_W = 3
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             diff,
   output logic [SEL_W-1:0] chan
);
   // differential pairs start on the even input
   assign chan = diff ? {sel[SEL_W-1:1], 1'b0} : sel;
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
   import scan_pkg::*;
#(
   parameter int NSLOT = 8,
   parameter int SEL_W = 3,
   parameter int TAG_W = $clog2(NSLOT),
   parameter int CNT_W = $clog2(NSLOT + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   par_mode,
   input  logic                   diff_mode,
   input  logic [NSLOT*SEL_W-1:0] sel_flat,
   input  logic [CNT_W-1:0]       count,
   input  logic                   done_a,
   input  logic                   done_b,
   output logic                   req_a,
   output logic                   req_b,
   output logic [TAG_W-1:0]       tag_a,
   output logic [TAG_W-1:0]       tag_b,
   output logic [SEL_W-1:0]       sel_a,
   output logic [SEL_W-1:0]       sel_b,
   output logic                   diff_q,
   output logic                   scan_done
);
   localparam int HALF = NSLOT / 2;

   scan_st_e               st;
   logic [CNT_W-1:0]       step;
   logic [CNT_W-1:0]       total;
   logic [CNT_W-1:0]       step_nx;
   logic [NSLOT*SEL_W-1:0] sel_q;
   logic                   par_q;
   logic                   got_a, got_b;
   logic                   ok_a, ok_b, last;

   assign step_nx = step + 1'b1;
   assign last    = (step_nx == total);
   assign ok_a    = got_a | done_a;
   assign ok_b    = ~par_q | got_b | done_b;

   assign tag_a = step[TAG_W-1:0];
   assign tag_b = tag_a + TAG_W'(HALF);
   assign sel_a = sel_q[tag_a*SEL_W +: SEL_W];
   assign sel_b = sel_q[tag_b*SEL_W +: SEL_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         step      <= '0;
         total     <= '0;
         sel_q     <= '0;
         par_q     <= 1'b0;
         diff_q    <= 1'b0;
         got_a     <= 1'b0;
         got_b     <= 1'b0;
         req_a     <= 1'b0;
         req_b     <= 1'b0;
         scan_done <= 1'b0;
      end else begin
         req_a     <= 1'b0;
         req_b     <= 1'b0;
         scan_done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  sel_q  <= sel_flat;
                  par_q  <= par_mode;
                  diff_q <= diff_mode;
                  total  <= count;
                  step   <= '0;
                  got_a  <= 1'b0;
                  got_b  <= 1'b0;
                  if (count == '0) begin
                     scan_done <= 1'b1;
                  end else begin
                     st    <= ST_BUSY;
                     req_a <= 1'b1;
                     req_b <= par_mode;
                  end
               end
            end
            ST_BUSY: begin
               if (ok_a && ok_b) begin
                  got_a <= 1'b0;
                  got_b <= 1'b0;
                  if (last) begin
                     st        <= ST_IDLE;
                     scan_done <= 1'b1;
                  end else begin
                     step  <= step_nx;
                     req_a <= 1'b1;
                     req_b <= par_q;
                  end
               end else begin
                  got_a <= ok_a;
                  got_b <= got_b | done_b;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R2
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_a |-> (st == ST_BUSY));

   // R3
   tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_a |-> (step < total));

   // R4
   pair_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_b |-> (req_a && par_q));

   // R4
   pair_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_b |-> (tag_a < TAG_W'(HALF) && tag_b == tag_a + TAG_W'(HALF)));

   // R6
   wait_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BUSY && !got_a && !done_a) |=> (!req_a && !scan_done));

   // R8
   req_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(scan_done && (req_a || req_b)));
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
   parameter int NSLOT   = 8,
   parameter int SEL_W   = 3,
   parameter int FIELD_W = 4,
   parameter int LIST_W  = (NSLOT / 2) * FIELD_W,
   parameter int TAG_W   = $clog2(NSLOT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LIST_W-1:0] list_lo,
   input  logic [LIST_W-1:0] list_hi,
   input  logic [NSLOT-1:0]  dis_mask,
   input  logic              par_mode,
   input  logic              diff_mode,
   input  logic              start,
   input  logic              done_a,
   input  logic              done_b,
   output logic              req_a,
   output logic [SEL_W-1:0]  chan_a,
   output logic              diff_a,
   output logic [TAG_W-1:0]  tag_a,
   output logic              req_b,
   output logic [SEL_W-1:0]  chan_b,
   output logic              diff_b,
   output logic [TAG_W-1:0]  tag_b,
   output logic              scan_done
);
   localparam int HALF  = NSLOT / 2;
   localparam int CNT_W = $clog2(NSLOT + 1);
   localparam int NCONV = 2;

   generate
      if (NSLOT < 2 || (NSLOT % 2) != 0) begin : g_bad_nslot
         $error("NSLOT must be even and at least 2");
      end
      if (FIELD_W < SEL_W) begin : g_bad_field
         $error("FIELD_W must hold SEL_W bits");
      end
      if (LIST_W != HALF * FIELD_W) begin : g_bad_list
         $error("LIST_W must equal HALF*FIELD_W");
      end
   endgenerate

   logic [NSLOT*SEL_W-1:0] sel_flat;
   logic                   unused_rsv;
   assign unused_rsv = ^{list_lo, list_hi};

   genvar k;
   generate
      for (k = 0; k < HALF; k++) begin : g_unpack
         assign sel_flat[k*SEL_W +: SEL_W]          = list_lo[k*FIELD_W +: SEL_W];
         assign sel_flat[(k+HALF)*SEL_W +: SEL_W]   = list_hi[k*FIELD_W +: SEL_W];
      end
   endgenerate

   logic [CNT_W-1:0] count;

   scan_limit #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_limit (
      .dis_mask (dis_mask),
      .par_mode (par_mode),
      .count    (count)
   );

   logic [SEL_W-1:0] sel_a, sel_b;
   logic             diff_q;

   scan_ctrl #(.NSLOT(NSLOT), .SEL_W(SEL_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .par_mode  (par_mode),
      .diff_mode (diff_mode),
      .sel_flat  (sel_flat),
      .count     (count),
      .done_a    (done_a),
      .done_b    (done_b),
      .req_a     (req_a),
      .req_b     (req_b),
      .tag_a     (tag_a),
      .tag_b     (tag_b),
      .sel_a     (sel_a),
      .sel_b     (sel_b),
      .diff_q    (diff_q),
      .scan_done (scan_done)
   );

   logic [SEL_W-1:0] sel_v  [NCONV];
   logic [SEL_W-1:0] chan_v [NCONV];
   assign sel_v[0] = sel_a;
   assign sel_v[1] = sel_b;

   genvar c;
   generate
      for (c = 0; c < NCONV; c++) begin : g_enc
         chan_encode #(.SEL_W(SEL_W)) u_enc (
            .sel  (sel_v[c]),
            .diff (diff_q),
            .chan (chan_v[c])
         );
      end
   endgenerate

   assign chan_a = chan_v[0];
   assign chan_b = chan_v[1];
   assign diff_a = diff_q;
   assign diff_b = diff_q;
endmodule

// File: tb/tb_scan_sequencer.sv
module tb_scan_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] list_lo = '0, list_hi = '0;
   logic [7:0]  dis_mask = '0;
   logic        par_mode = 1'b0, diff_mode = 1'b0, start = 1'b0;
   logic        done_a = 1'b0, done_b = 1'b0;
   logic        req_a, req_b, diff_a, diff_b, scan_done;
   logic [2:0]  chan_a, chan_b, tag_a, tag_b;

   always #10 clk = ~clk;   // 50 MHz

   scan_sequencer dut (
      .clk(clk), .rst_n(rst_n), .list_lo(list_lo), .list_hi(list_hi),
      .dis_mask(dis_mask), .par_mode(par_mode), .diff_mode(diff_mode),
      .start(start), .done_a(done_a), .done_b(done_b),
      .req_a(req_a), .chan_a(chan_a), .diff_a(diff_a), .tag_a(tag_a),
      .req_b(req_b), .chan_b(chan_b), .diff_b(diff_b), .tag_b(tag_b),
      .scan_done(scan_done)
   );

   int    checks = 0, errors = 0, cycles = 0;
   bit    fin = 0;
   string cur_req = "R1";

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   int  m_sel[8];
   int  m_q[$];
   bit  m_busy = 0, m_par = 0, m_diff = 0, m_got_a = 0, m_got_b = 0;
   bit  e_req_a = 0, e_req_b = 0, e_done = 0;
   int  e_tag_a = 0, e_tag_b = 0, e_chan_a = 0, e_chan_b = 0;

   function automatic int slot_of(input logic [15:0] lo, input logic [15:0] hi, input int k);
      logic [15:0] w;
      w = (k < 4) ? lo : hi;
      return int'((w >> (4 * (k % 4))) & 16'h7);
   endfunction

   function automatic int enc(input int v, input bit d);
      return d ? (v / 2) * 2 : v;
   endfunction

   task automatic issue();
      e_req_a  = 1;
      e_tag_a  = m_q[0];
      e_chan_a = enc(m_sel[m_q[0]], m_diff);
      if (m_par) begin
         e_req_b  = 1;
         e_tag_b  = m_q[0] + 4;
         e_chan_b = enc(m_sel[m_q[0] + 4], m_diff);
      end
      m_got_a = 0;
      m_got_b = 0;
   endtask

   always @(posedge clk) begin
      bit ok_a, ok_b;
      if (!rst_n) begin
         m_busy = 0; e_req_a = 0; e_req_b = 0; e_done = 0;
         m_q.delete();
      end else begin
         e_req_a = 0; e_req_b = 0; e_done = 0;
         if (!m_busy) begin
            if (start) begin
               for (int k = 0; k < 8; k++) m_sel[k] = slot_of(list_lo, list_hi, k);
               m_par  = par_mode;
               m_diff = diff_mode;
               m_q.delete();
               if (!m_par) begin
                  for (int k = 0; k < 8; k++) begin
                     if (dis_mask[k]) break;
                     m_q.push_back(k);
                  end
               end else begin
                  for (int j = 0; j < 4; j++) begin
                     if (dis_mask[j] || dis_mask[j + 4]) break;
                     m_q.push_back(j);
                  end
               end
               if (m_q.size() == 0) e_done = 1;
               else begin
                  m_busy = 1;
                  issue();
               end
            end
         end else begin
            ok_a = m_got_a || done_a;
            ok_b = !m_par || m_got_b || done_b;
            if (ok_a && ok_b) begin
               void'(m_q.pop_front());
               if (m_q.size() == 0) begin
                  e_done = 1;
                  m_busy = 0;
               end else issue();
            end else begin
               m_got_a = ok_a;
               m_got_b = m_got_b || done_b;
            end
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !fin) begin
         chk(req_a === e_req_a, "req_a", int'(req_a), int'(e_req_a));
         chk(req_b === e_req_b, "req_b", int'(req_b), int'(e_req_b));
         chk(scan_done === e_done, "scan_done", int'(scan_done), int'(e_done));
         if (e_req_a) begin
            chk(int'(tag_a) == e_tag_a, "tag_a", int'(tag_a), e_tag_a);
            chk(int'(chan_a) == e_chan_a, "chan_a", int'(chan_a), e_chan_a);
            chk(diff_a === m_diff, "diff_a", int'(diff_a), int'(m_diff));
         end
         if (e_req_b) begin
            chk(int'(tag_b) == e_tag_b, "tag_b", int'(tag_b), e_tag_b);
            chk(int'(chan_b) == e_chan_b, "chan_b", int'(chan_b), e_chan_b);
            chk(diff_b === m_diff, "diff_b", int'(diff_b), int'(m_diff));
         end
      end
   end

   // ---------------- converter responders ----------------
   int lat_a = 0, lat_b = 0, cnt_a = 0, cnt_b = 0, nreq_a = 0, nreq_b = 0;

   always @(negedge clk) begin
      done_a = 0;
      done_b = 0;
      if (cnt_a > 0) begin
         cnt_a--;
         if (cnt_a == 0) done_a = 1;
      end
      if (cnt_b > 0) begin
         cnt_b--;
         if (cnt_b == 0) done_b = 1;
      end
      if (req_a === 1'b1) begin
         nreq_a++;
         cnt_a = lat_a;
         if (lat_a == 0) done_a = 1;
      end
      if (req_b === 1'b1) begin
         nreq_b++;
         cnt_b = lat_b;
         if (lat_b == 0) done_b = 1;
      end
   end

   // ---------------- scan driver ----------------
   task automatic run_scan(input logic [15:0] lo, input logic [15:0] hi, input logic [7:0] m,
                           input bit p, input bit d, input int la, input int lb,
                           input int exp_n, input bit hold, input bit mutate, input string rq);
      int cyc;
      @(negedge clk);
      cur_req = rq;
      list_lo = lo; list_hi = hi; dis_mask = m;
      par_mode = p; diff_mode = d;
      lat_a = la; lat_b = lb;
      nreq_a = 0; nreq_b = 0;
      start = 1;
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
         if (!hold) start = 0;
         if (mutate && cyc == 2) begin
            list_lo = ~lo; list_hi = ~hi; dis_mask = 8'h01;
            par_mode = ~p; diff_mode = ~d;
         end
      end while (scan_done !== 1'b1 && cyc < 300);
      start = 0;
      chk(scan_done === 1'b1, "scan ended", int'(scan_done), 1);
      chk(nreq_a == exp_n, "req_a count", nreq_a, exp_n);
      chk(nreq_b == (p ? exp_n : 0), "req_b count", nreq_b, p ? exp_n : 0);
      if (exp_n == 0) chk(cyc == 1, "empty scan latency", cyc, 1);
      repeat (2) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !fin) begin
         fin = 1;
         errors++;
         $display("FAIL watchdog act=%0d exp=%0d", cycles, 50000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: outputs quiet under reset and just after release
      repeat (3) @(negedge clk);
      cur_req = "R1";
      chk(req_a === 1'b0, "req_a in reset", int'(req_a), 0);
      chk(req_b === 1'b0, "req_b in reset", int'(req_b), 0);
      chk(scan_done === 1'b0, "scan_done in reset", int'(scan_done), 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(req_a === 1'b0 && scan_done === 1'b0, "idle after reset", int'(req_a), 0);

      // R2 R11: full single-converter list, reserved bits set
      run_scan(16'h9C3E, 16'hF1D7, 8'h00, 0, 0, 1, 0, 8, 0, 0, "R2");
      run_scan(16'hFEDC, 16'hBA98, 8'h00, 0, 0, 0, 0, 8, 0, 0, "R11");
      // R3: lowest disabled slot ends the list
      run_scan(16'h3210, 16'h7654, 8'h20, 0, 0, 0, 0, 5, 0, 0, "R3");
      run_scan(16'h3210, 16'h7654, 8'h24, 0, 0, 2, 0, 2, 0, 0, "R3");
      // R4 R6: paired scan, A slower than B, then B slower than A
      run_scan(16'h5273, 16'h0614, 8'h00, 1, 0, 2, 0, 4, 0, 0, "R4");
      run_scan(16'h5273, 16'h0614, 8'h00, 1, 0, 0, 3, 4, 0, 0, "R6");
      // R8: both dones in the same cycle
      run_scan(16'h1357, 16'h2460, 8'h00, 1, 0, 1, 1, 4, 0, 0, "R8");
      // R5: pair cut by either half
      run_scan(16'h3210, 16'h7654, 8'h20, 1, 0, 0, 0, 1, 0, 0, "R5");
      run_scan(16'h3210, 16'h7654, 8'h02, 1, 0, 1, 2, 1, 0, 0, "R5");
      run_scan(16'h3210, 16'h7654, 8'h04, 1, 0, 0, 1, 2, 0, 0, "R5");
      // R7: empty scans
      run_scan(16'h3210, 16'h7654, 8'h01, 0, 0, 0, 0, 0, 0, 0, "R7");
      run_scan(16'h3210, 16'h7654, 8'h10, 1, 0, 0, 0, 0, 0, 0, "R7");
      // R10: differential encoding
      run_scan(16'h7351, 16'h6420, 8'h00, 0, 1, 0, 0, 8, 0, 0, "R10");
      run_scan(16'h3715, 16'h2604, 8'h00, 1, 1, 1, 0, 4, 0, 0, "R10");
      // R9: start held high for the whole scan, including the final done cycle
      run_scan(16'h2461, 16'h7035, 8'h08, 0, 0, 2, 0, 3, 1, 0, "R9");
      // R12: inputs altered mid-scan
      run_scan(16'h4321, 16'h0765, 8'h00, 0, 0, 3, 0, 8, 0, 1, "R12");
      run_scan(16'h4321, 16'h0765, 8'h00, 1, 0, 2, 2, 4, 0, 1, "R12");

      // R6: stray dones while idle start nothing
      cur_req = "R6";
      @(negedge clk);
      lat_a = 0;
      force_idle_dones();
      fin = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic force_idle_dones();
      int seen;
      seen = 0;
      for (int i = 0; i < 4; i++) begin
         cnt_a = 1;
         cnt_b = 1;
         @(negedge clk);
         if (req_a === 1'b1 || req_b === 1'b1 || scan_done === 1'b1) seen++;
      end
      repeat (2) @(negedge clk);
      if (req_a === 1'b1 || scan_done === 1'b1) seen++;
      chk(seen == 0, "idle dones ignored", seen, 0);
   endtask
endmodule